// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the host side of a two-wire debug link. Each transaction is either a read or a write to a debug or access port on the target. A controller places a request on the inputs and pulses `start`. The request holds the port select, the read/write flag, two address bits and a timestamp flag. For a write, the controller also supplies a 32-bit word. The engine then produces the debug clock and, bit by bit, steers the data line: it drives the line when sending and releases it when receiving.

When the transaction is complete, the engine raises `done` for one cycle. At that point it has registered the 3-bit acknowledge, the read word, a parity-error flag and, when the timestamp flag was set, a microsecond timestamp.

The turnaround length can be set from one to four clocks. A programmable number of low-driven idle clocks follows each accepted transfer. If the acknowledge is not a recognised code, the engine stays off the line for a full turnaround plus data-plus-parity span before it drives again.

Top module: `swd_xfer_engine`

## Requirements
- R1: The request is sent as eight driven bit slots, LSB first. In transmit order the slots carry: a 1, the port select, the read/write flag, `req_addr[0]`, `req_addr[1]`, the even parity of those four fields, a 0, and a 1.
- R2: Each turnaround lasts `turn_sel`+1 bit slots. During a turnaround `swdio_oe` is 0, and any value the target places on `swdio_i` does not affect any result.
- R3: The acknowledge is sampled on three released slots straight after the first turnaround. The first slot lands in `ack[0]`. The codes are OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100.
- R4: On an OK read, the engine samples 32 data bits LSB first and then one parity bit, all on released slots. It then releases the line for one more turnaround before driving it again. `rdata` shows the sampled word.
- R5: On an OK read, if the received parity bit differs from the XOR of the 32 data bits, the engine returns `ack` = 3'b000 and sets `par_err` to 1. Otherwise `par_err` is 0.
- R6: On an OK write, the engine releases the line for one turnaround. It then drives `wdata` LSB first on 32 slots, followed by one slot carrying the XOR of those bits.
- R7: After an OK transfer, the engine drives `swdio_o` low with `swdio_oe` at 1 for exactly `idle_cnt` slots. When `idle_cnt` is 0, no such slots are added.
- R8: On WAIT or FAULT, the engine releases the line for one turnaround, drives no data slots, and returns the acknowledge unchanged.
- R9: On any other acknowledge, the line stays released for `turn_sel`+1+33 slots, and the raw acknowledge is returned with `par_err` at 0.
- R10: When `req_ts` is set and the acknowledge is OK, `stamp` captures the free-running microsecond count at the end of the data phase. In every other case `stamp` keeps its value.
- R11: `swdio_o` and `swdio_oe` change only while `swclk` is low, and the engine samples `swdio_i` on the rising edge. While idle, `swclk` is 0, `swdio_oe` is 1 and `swdio_o` is 0.
- R12: `start` is ignored while `busy` is 1. `done` is a one-cycle pulse that coincides with `busy` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted only while idle) |
| req_apndp | input | 1 | Port select: 0 debug port, 1 access port |
| req_rnw | input | 1 | 1 read, 0 write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_ts | input | 1 | Capture a timestamp on success |
| wdata | input | 32 | Word to write |
| turn_sel | input | 2 | Turnaround length minus one |
| idle_cnt | input | IDLE_W | Idle clocks after an OK transfer |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ack | output | 3 | Returned acknowledge or result code |
| rdata | output | 32 | Word received by the last OK read |
| par_err | output | 1 | Read parity mismatch flag |
| stamp | output | TS_W | Captured microsecond count |
| swclk | output | 1 | Debug clock |
| swdio_o | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input value |

## Verification
If the slot counter or the phase state is wrong, the fault appears on the very next rising edge of `swclk`. The symptom is a driven slot where a released one was expected, or the reverse, or a wrong bit value. The same fault also moves `done` earlier or later by whole slots. A corrupted receive shift register or parity accumulator cannot be seen on the line itself. It is exposed only at `done`, through a wrong `rdata`, a wrong `ack` or a wrong `par_err`. The bench therefore checks every bit slot as it happens and checks every result at completion.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int WORD_W = 32;
  localparam int REQ_W  = 8;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  typedef enum logic [3:0] {
    S_OFF, S_REQ, S_TRN1, S_ACK, S_RDAT, S_RPAR,
    S_TRN2, S_WDAT, S_WPAR, S_IDLE, S_RECOV
  } seq_state_t;
endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic swclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] div_q;
  logic          wrap;

  assign wrap      = en && (div_q == CW'(HALF_DIV - 1));
  assign rise_tick = wrap && !swclk;
  assign fall_tick = wrap && swclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q <= '0;
      swclk <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      swclk <= ~swclk;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/swd_us_timer.sv
module swd_us_timer #(
  parameter int US_DIV = 200,
  parameter int TS_W   = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now_us
);
  localparam int PW = (US_DIV > 1) ? $clog2(US_DIV) : 1;

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      now_us <= '0;
    end else if (pre_q == PW'(US_DIV - 1)) begin
      pre_q  <= '0;
      now_us <= now_us + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_pkg::*;
#(
  parameter int IDLE_W = 8,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              req_apndp,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic              req_ts,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        turn_sel,
  input  logic [IDLE_W-1:0] idle_cnt,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              swdio_i,
  input  logic [TS_W-1:0]   now_us,
  output logic              busy,
  output logic              done,
  output logic [2:0]        ack,
  output logic [WORD_W-1:0] rdata,
  output logic              par_err,
  output logic [TS_W-1:0]   stamp,
  output logic              swdio_o,
  output logic              swdio_oe
);
  localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;

  seq_state_t        st, nx_st;
  logic [CNT_W-1:0]  cnt, nx_cnt;
  logic              nx_oe, nx_o;
  logic [REQ_W-1:0]  rq;
  logic [WORD_W-1:0] sh;
  logic              wpar, rpar, bad;
  logic [2:0]        ack_sh;
  logic              l_rnw, l_ts;
  logic [1:0]        l_turn;
  logic [IDLE_W-1:0] l_idle;
  logic              req_par;
  logic              ack_is_ok;

  assign req_par   = req_apndp ^ req_rnw ^ req_addr[0] ^ req_addr[1];
  assign ack_is_ok = (ack_sh == ACK_OK);

  // decision taken when the current phase's last slot ends
  always_comb begin
    nx_st  = S_OFF;
    nx_cnt = '0;
    nx_oe  = 1'b1;
    nx_o   = 1'b0;
    unique case (st)
      S_REQ: begin
        nx_st = S_TRN1; nx_cnt = CNT_W'(l_turn); nx_oe = 1'b0;
      end
      S_TRN1: begin
        nx_st = S_ACK; nx_cnt = CNT_W'(2); nx_oe = 1'b0;
      end
      S_ACK: begin
        nx_oe = 1'b0;
        if (ack_is_ok && l_rnw) begin
          nx_st = S_RDAT; nx_cnt = CNT_W'(WORD_W - 1);
        end else if (ack_is_ok || ack_sh == ACK_WAIT || ack_sh == ACK_FAULT) begin
          nx_st = S_TRN2; nx_cnt = CNT_W'(l_turn);
        end else begin
          nx_st = S_RECOV; nx_cnt = CNT_W'(l_turn) + CNT_W'(WORD_W + 1);
        end
      end
      S_RDAT: begin
        nx_st = S_RPAR; nx_oe = 1'b0;
      end
      S_RPAR: begin
        nx_st = S_TRN2; nx_cnt = CNT_W'(l_turn); nx_oe = 1'b0;
      end
      S_TRN2: begin
        if (ack_is_ok && !l_rnw) begin
          nx_st = S_WDAT; nx_cnt = CNT_W'(WORD_W - 1); nx_o = sh[0];
        end else if (ack_is_ok && l_idle != '0) begin
          nx_st = S_IDLE; nx_cnt = CNT_W'(l_idle) - 1'b1;
        end
      end
      S_WDAT: begin
        nx_st = S_WPAR; nx_o = wpar;
      end
      S_WPAR: begin
        if (l_idle != '0) begin
          nx_st = S_IDLE; nx_cnt = CNT_W'(l_idle) - 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_OFF; cnt <= '0; rq <= '0; sh <= '0;
      wpar <= 1'b0; rpar <= 1'b0; bad <= 1'b0; ack_sh <= '0;
      l_rnw <= 1'b0; l_ts <= 1'b0; l_turn <= '0; l_idle <= '0;
      busy <= 1'b0; done <= 1'b0; ack <= '0; rdata <= '0;
      par_err <= 1'b0; stamp <= '0;
      swdio_o <= 1'b0; swdio_oe <= 1'b1;
    end else begin
      done <= 1'b0;
      if (st == S_OFF) begin
        if (start) begin
          rq       <= {1'b1, 1'b0, req_par, req_addr[1], req_addr[0], req_rnw, req_apndp, 1'b1};
          sh       <= wdata;
          wpar     <= ^wdata;
          l_rnw    <= req_rnw;
          l_ts     <= req_ts;
          l_turn   <= turn_sel;
          l_idle   <= idle_cnt;
          ack_sh   <= '0;
          bad      <= 1'b0;
          cnt      <= CNT_W'(REQ_W - 1);
          st       <= S_REQ;
          busy     <= 1'b1;
          swdio_oe <= 1'b1;
          swdio_o  <= 1'b1;
        end
      end else begin
        if (rise_tick) begin
          unique case (st)
            S_ACK:   ack_sh <= {swdio_i, ack_sh[2:1]};
            S_RDAT:  sh     <= {swdio_i, sh[WORD_W-1:1]};
            S_RPAR:  rpar   <= swdio_i;
            default: ;
          endcase
        end
        if (fall_tick) begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (st == S_REQ) begin
              swdio_o <= rq[1];
              rq      <= {1'b0, rq[REQ_W-1:1]};
            end
            if (st == S_WDAT) begin
              swdio_o <= sh[1];
              sh      <= {1'b0, sh[WORD_W-1:1]};
            end
          end else begin
            st       <= nx_st;
            cnt      <= nx_cnt;
            swdio_oe <= nx_oe;
            swdio_o  <= nx_o;
            if (st == S_RPAR) begin
              bad   <= rpar ^ (^sh);
              rdata <= sh;
              if (l_ts) stamp <= now_us;
            end
            if (st == S_WPAR && l_ts) stamp <= now_us;
            if (nx_st == S_OFF) begin
              busy    <= 1'b0;
              done    <= 1'b1;
              ack     <= (ack_is_ok && l_rnw && bad) ? 3'b000 : ack_sh;
              par_err <= ack_is_ok && l_rnw && bad;
            end
          end
        end
      end
    end
  end

  // R5: a parity error always reports the zero code
  a_r5_perr_zero_code: assert property (@(posedge clk) disable iff (rst)
    par_err |-> (ack == 3'b000));

  // R3, R8, R9: data slots happen only after an OK acknowledge
  a_r3_data_needs_ok: assert property (@(posedge clk) disable iff (rst)
    (st == S_RDAT || st == S_WDAT || st == S_IDLE) |-> ack_is_ok);

  // R9: recovery never drives the line
  a_r9_recovery_released: assert property (@(posedge clk) disable iff (rst)
    (st == S_RECOV) |-> !swdio_oe);
endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
  import swd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int US_DIV   = 200,
  parameter int IDLE_W   = 8,
  parameter int TS_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              req_apndp,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic              req_ts,
  input  logic [31:0]       wdata,
  input  logic [1:0]        turn_sel,
  input  logic [IDLE_W-1:0] idle_cnt,
  output logic              busy,
  output logic              done,
  output logic [2:0]        ack,
  output logic [31:0]       rdata,
  output logic              par_err,
  output logic [TS_W-1:0]   stamp,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);
  logic            rise_tick, fall_tick;
  logic [TS_W-1:0] now_us;

  swd_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
    .clk(clk), .rst(rst), .en(busy),
    .swclk(swclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  swd_us_timer #(.US_DIV(US_DIV), .TS_W(TS_W)) timer_i (
    .clk(clk), .rst(rst), .now_us(now_us)
  );

  swd_seq #(.IDLE_W(IDLE_W), .TS_W(TS_W)) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .req_apndp(req_apndp), .req_rnw(req_rnw), .req_addr(req_addr),
    .req_ts(req_ts), .wdata(wdata), .turn_sel(turn_sel), .idle_cnt(idle_cnt),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .swdio_i(swdio_i),
    .now_us(now_us), .busy(busy), .done(done), .ack(ack), .rdata(rdata),
    .par_err(par_err), .stamp(stamp), .swdio_o(swdio_o), .swdio_oe(swdio_oe)
  );

  // R11: quiet line while idle
  a_r11_idle_line: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!swclk && swdio_oe && !swdio_o));

  // R11: line changes only while the clock is low
  a_r11_change_on_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(swdio_o) || !$stable(swdio_oe)) |-> !swclk);

  // R12: completion is a single-cycle pulse with busy released
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));

  // R1: the first slot of a transaction drives the start bit
  a_r1_start_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (swdio_oe && swdio_o));
endmodule

// File: tb/swd_xfer_engine_tb.sv
module swd_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        req_apndp = 1'b0, req_rnw = 1'b0, req_ts = 1'b0;
  logic [1:0]  req_addr = 2'b00, turn_sel = 2'b00;
  logic [31:0] wdata = '0;
  logic [7:0]  idle_cnt = '0;
  logic        busy, done, par_err, swclk, swdio_o, swdio_oe;
  logic        swdio_i = 1'b0;
  logic [2:0]  ack;
  logic [31:0] rdata, stamp;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] exp_rdata = '0;
  logic [31:0] exp_stamp = '0;
  logic [2:0]  q[$];  // {oe, o, target bit}

  always #2.5 clk = ~clk;  // 200 MHz

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  swd_xfer_engine dut_i (
    .clk(clk), .rst(rst), .start(start), .req_apndp(req_apndp),
    .req_rnw(req_rnw), .req_addr(req_addr), .req_ts(req_ts),
    .wdata(wdata), .turn_sel(turn_sel), .idle_cnt(idle_cnt),
    .busy(busy), .done(done), .ack(ack), .rdata(rdata),
    .par_err(par_err), .stamp(stamp), .swclk(swclk),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R11 idle line", {29'd0, swclk, swdio_oe, swdio_o}, 32'b010);
      chk("R12 no spurious start", {31'd0, busy}, 32'd0);
    end
  endtask

  task automatic run_xfer(input string tag, input logic apndp, input logic rnw,
                          input logic [1:0] a, input logic ts, input logic [31:0] wd,
                          input logic [1:0] tsel, input logic [7:0] idl,
                          input logic [2:0] ackv, input logic [31:0] rd,
                          input logic badp, input logic poke);
    int t = tsel + 1;
    logic [7:0] pkt;
    logic [2:0] exp_ack;
    logic exp_perr = 1'b0;
    logic prev_sw = 1'b0;
    int n = 0;
    int t0, t1;
    pkt = {1'b1, 1'b0, apndp ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, apndp, 1'b1};
    q.delete();
    for (int i = 0; i < 8; i++) q.push_back({1'b1, pkt[i], 1'b0});          // R1
    for (int i = 0; i < t; i++) q.push_back({2'b00, i[0] ^ 1'b1});          // R2 junk
    for (int i = 0; i < 3; i++) q.push_back({2'b00, ackv[i]});              // R3
    exp_ack = ackv;
    if (ackv == 3'b001) begin
      if (rnw) begin
        for (int i = 0; i < 32; i++) q.push_back({2'b00, rd[i]});           // R4
        q.push_back({2'b00, (^rd) ^ badp});
        for (int i = 0; i < t; i++) q.push_back({2'b00, 1'b1});
        exp_rdata = rd;
        if (badp) begin exp_ack = 3'b000; exp_perr = 1'b1; end              // R5
      end else begin
        for (int i = 0; i < t; i++) q.push_back({2'b00, 1'b1});
        for (int i = 0; i < 32; i++) q.push_back({1'b1, wd[i], 1'b0});      // R6
        q.push_back({1'b1, ^wd, 1'b0});
      end
      for (int i = 0; i < idl; i++) q.push_back(3'b100);                    // R7
    end else if (ackv == 3'b010 || ackv == 3'b100) begin
      for (int i = 0; i < t; i++) q.push_back({2'b00, 1'b1});               // R8
    end else begin
      for (int i = 0; i < t + 33; i++) q.push_back({2'b00, (i % 3) == 0});  // R9
    end
    req_apndp = apndp; req_rnw = rnw; req_addr = a; req_ts = ts;
    wdata = wd; turn_sel = tsel; idle_cnt = idl;
    swdio_i = q[0][0];
    start = 1'b1;
    t0 = cyc / 200;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R12 busy after start"}, {31'd0, busy}, 32'd1);
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 12) begin
        start = 1'b1; req_rnw = ~rnw; req_apndp = ~apndp; turn_sel = ~tsel;
      end
      if (poke && n == 13) start = 1'b0;
      if (swclk && !prev_sw) begin
        if (q.size() == 0) begin
          chk({tag, " R11 extra slot"}, 32'd1, 32'd0);
        end else begin
          logic [2:0] s = q.pop_front();
          chk({tag, " R2/R11 slot oe"}, {31'd0, swdio_oe}, {31'd0, s[2]});
          if (s[2]) chk({tag, " R1/R6/R7 slot data"}, {31'd0, swdio_o}, {31'd0, s[1]});
          if (q.size() != 0) swdio_i = q[0][0];
        end
      end
      prev_sw = swclk;
    end
    if (!done) begin
      fails++;
      $display("FAIL %s R12 watchdog: actual no done expected done", tag);
      return;
    end
    t1 = cyc / 200;
    chk({tag, " R12 slots consumed"}, q.size(), 32'd0);
    chk({tag, " R12 busy low at done"}, {31'd0, busy}, 32'd0);
    chk({tag, " R3/R8/R9 ack"}, {29'd0, ack}, {29'd0, exp_ack});
    chk({tag, " R5 par_err"}, {31'd0, par_err}, {31'd0, exp_perr});
    chk({tag, " R4 rdata"}, rdata, exp_rdata);
    if (ts && ackv == 3'b001) begin
      vectors++;
      if (stamp + 1 < t0 || stamp > t1 + 1) begin
        fails++;
        $display("FAIL %s R10 stamp: actual %0d expected %0d..%0d", tag, stamp, t0, t1);
      end
      exp_stamp = stamp;
    end else begin
      chk({tag, " R10 stamp held"}, stamp, exp_stamp);
    end
    idle_wait(6);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset swclk", {31'd0, swclk}, 32'd0);
    chk("R12 reset busy", {31'd0, busy}, 32'd0);
    chk("R12 reset done", {31'd0, done}, 32'd0);
    chk("R3 reset ack", {29'd0, ack}, 32'd0);
    chk("R4 reset rdata", rdata, 32'd0);
    chk("R10 reset stamp", stamp, 32'd0);
    idle_wait(4);
    run_xfer("rd_ok",    1'b1, 1'b1, 2'b01, 1'b0, 32'h0,        2'd0, 8'd0, 3'b001, 32'hA5C3_0F71, 1'b0, 1'b0);
    run_xfer("wr_ok",    1'b0, 1'b0, 2'b10, 1'b1, 32'h8001_3C5E, 2'd1, 8'd3, 3'b001, 32'h0,        1'b0, 1'b0);
    run_xfer("rd_badpar",1'b0, 1'b1, 2'b11, 1'b0, 32'h0,        2'd3, 8'd2, 3'b001, 32'h1234_5678, 1'b1, 1'b0);
    run_xfer("rd_ts",    1'b1, 1'b1, 2'b00, 1'b1, 32'h0,        2'd2, 8'd0, 3'b001, 32'hFFFF_0000, 1'b0, 1'b0);
    run_xfer("wait",     1'b1, 1'b0, 2'b01, 1'b1, 32'hDEAD_BEEF, 2'd1, 8'd5, 3'b010, 32'h0,        1'b0, 1'b0);
    run_xfer("fault",    1'b0, 1'b1, 2'b10, 1'b0, 32'h0,        2'd0, 8'd1, 3'b100, 32'h0,        1'b0, 1'b0);
    run_xfer("proto111", 1'b1, 1'b1, 2'b11, 1'b0, 32'h0,        2'd2, 8'd4, 3'b111, 32'h0,        1'b0, 1'b0);
    run_xfer("proto000", 1'b0, 1'b0, 2'b00, 1'b0, 32'h5555_AAAA, 2'd3, 8'd0, 3'b000, 32'h0,        1'b0, 1'b0);
    run_xfer("wr_poke",  1'b0, 1'b0, 2'b01, 1'b0, 32'h0F0F_F0F1, 2'd0, 8'd1, 3'b001, 32'h0,        1'b0, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL global watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule